// File: doc/BRIEF.md
# Round-Key Generator with Borrowed Substitution Port

This block holds one 128-bit cipher key and derives the full AES-128 key schedule from it. It produces 44 words of 32 bits and keeps them in a local register file. A column-serial round datapath pulls round-key words one per request. For encryption the words come in forward order. For decryption the round keys come last round first. Within each round key, the columns still come in ascending order.

The generator owns no substitution table. For each word that needs SubWord, it raises a request on an external four-byte S-box port and holds the word there. The request completes in the cycle the round datapath signals that its S-boxes are idle, which happens during its mixing and key-addition cycles. The substituted word comes back a fixed number of cycles later, set by `SBOX_LAT`. Words that need no substitution take one cycle each.

A key load restarts the schedule. The direction input is sampled at the first word of each pass through the schedule.

The key width is set by the parameter `NK`, the number of 32-bit words in the key. The round count and the word count follow from it. For `NK` above 6, an extra substitution-only step is taken at key column 4.

Top module: `kx_key_sched`

## Requirements
- R1: After reset, `ready_o`, `rk_valid_o` and `sbox_req_o` are all low, and stay low until a key is loaded.
- R2: `key_i[127:96]` is schedule word 0 and `key_i[31:0]` is word 3. Byte 0 of every word sits in bits [31:24]. In encryption order, successive reads return words 0, 1, …, 43 of the standard AES-128 key expansion.
- R3: In decryption order, reads return the four words of round key 10, then round key 9, and so on down to round key 0. Within one round key the words come in ascending column order: words 4r, 4r+1, 4r+2, 4r+3.
- R4: For encryption, `ready_o` is high as soon as the word at the read position has been generated, which is the cycle after a key load for word 0. For decryption, `ready_o` stays low until all 44 words exist.
- R5: When a word needs substitution, `sbox_req_o` rises and `sbox_word_o` carries the previous word rotated by one byte: {w[23:0], w[31:24]}. Both hold unchanged through every cycle with `sbox_free_i` low.
- R6: A request is consumed by the first cycle in which `sbox_req_o` and `sbox_free_i` are both high. `sbox_req_o` is low in the next cycle. A full AES-128 expansion takes exactly 10 such grant cycles.
- R7: The substitution result is taken from `sbox_res_i` exactly `SBOX_LAT` cycles after the grant cycle. The value on `sbox_res_i` in any other cycle has no effect on the schedule.
- R8: The round constant XORed into byte 0 of each substituted word takes the values 0x01, 0x02, 0x04, …, 0x80, 0x1b, 0x36 in successive rounds. This gives word 4 = 0xa0fafe17 and word 43 = 0xb6630ca6 for key 0x2b7e151628aed2a6abf7158809cf4f3c.
- R9: A read request in a cycle where `ready_o` is low is ignored. No valid word follows, and the read position does not move.
- R10: After the last word of a pass, the read position returns to the start. `decrypt_i` is sampled only when the first word of a pass is accepted, and that direction holds for the rest of the pass.
- R11: `key_load_i` aborts any expansion or substitution in progress and restarts both the schedule and the read position with the new key. In the cycle after the load, `sbox_req_o` and `rk_valid_o` are low.
- R12: An accepted read (`rk_req_i` high with `ready_o` high and no key load) yields `rk_valid_o` high with the word on `rk_word_o` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_load_i | input | 1 | Load `key_i` and restart the schedule |
| key_i | input | 32*NK | Cipher key, word 0 in the top bits |
| decrypt_i | input | 1 | Read order for the next pass: 1 = reversed round order |
| rk_req_i | input | 1 | Request the next round-key word |
| ready_o | output | 1 | Next word for the current direction is available |
| rk_valid_o | output | 1 | `rk_word_o` holds a delivered word |
| rk_word_o | output | 32 | Round-key word |
| sbox_req_o | output | 1 | Substitution wanted on the shared S-box port |
| sbox_word_o | output | 32 | Word to substitute |
| sbox_free_i | input | 1 | Datapath S-boxes idle this cycle (grant) |
| sbox_res_i | input | 32 | Substituted word, `SBOX_LAT` cycles after grant |

## Verification
On every cycle, the checker covers the S-box port handshake and the read handshake. It confirms that a waiting request and its word stay put without a grant, and that a grant drops the request. It also confirms that an accepted read, and only an accepted read, yields a valid word one cycle later, and that a key load leaves both ports quiet in the following cycle. The schedule values, the reversed round ordering, the latency-exact sampling of the result, the round-constant sequence, the per-direction readiness and the restart on reload depend on data. Only the bench scenarios can show them. The bench does this by comparing whole passes against an independently computed expansion, under starved, alternating and continuous grant patterns, with junk driven on the result bus outside the sampling cycle.

// File: rtl/kx_pkg.sv
package kx_pkg;
  typedef logic [31:0] word_t;
  typedef enum logic [1:0] {SB_IDLE, SB_REQ, SB_WAIT} sb_state_e;

  function automatic word_t rot_word(input word_t w);
    return {w[23:0], w[31:24]};
  endfunction

  function automatic logic [7:0] gf_dbl(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction
endpackage

// File: rtl/kx_rcon_gen.sv
module kx_rcon_gen (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       step_i,
  output logic [7:0] rcon_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rcon_o <= 8'h01;
    else if (clear_i) rcon_o <= 8'h01;
    else if (step_i)  rcon_o <= kx_pkg::gf_dbl(rcon_o);
  end
endmodule

// File: rtl/kx_sbox_client.sv
module kx_sbox_client #(
  parameter int LAT = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               abort_i,
  input  logic               start_i,
  input  kx_pkg::word_t      word_i,
  input  logic               free_i,
  input  kx_pkg::word_t      res_i,
  output logic               req_o,
  output kx_pkg::word_t      word_o,
  output logic               busy_o,
  output logic               done_o,
  output kx_pkg::word_t      result_o
);
  import kx_pkg::*;
  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

  sb_state_e      st_q;
  logic [CW-1:0]  cnt_q;
  word_t          word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SB_IDLE;
      cnt_q  <= '0;
      word_q <= '0;
    end else if (abort_i) begin
      st_q <= SB_IDLE;
    end else begin
      case (st_q)
        SB_IDLE: if (start_i) begin
          word_q <= word_i;
          st_q   <= SB_REQ;
        end
        SB_REQ: if (free_i) begin
          cnt_q <= CW'(LAT - 1);
          st_q  <= SB_WAIT;
        end
        SB_WAIT: begin
          if (cnt_q == '0) st_q <= SB_IDLE;
          else             cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= SB_IDLE;
      endcase
    end
  end

  assign req_o    = (st_q == SB_REQ);
  assign word_o   = word_q;
  assign busy_o   = (st_q != SB_IDLE);
  assign done_o   = (st_q == SB_WAIT) && (cnt_q == '0);
  assign result_o = res_i;
endmodule

// File: rtl/kx_word_store.sv
module kx_word_store #(
  parameter int NK    = 4,
  parameter int DEPTH = 44,
  parameter int AW    = 6
) (
  input  logic               clk_i,
  input  logic               load_i,
  input  logic [32*NK-1:0]   key_i,
  input  logic               we_i,
  input  logic [AW-1:0]      waddr_i,
  input  kx_pkg::word_t      wdata_i,
  input  logic [AW-1:0]      ra_i,
  input  logic [AW-1:0]      rb_i,
  input  logic [AW-1:0]      rc_i,
  output kx_pkg::word_t      ra_o,
  output kx_pkg::word_t      rb_o,
  output kx_pkg::word_t      rc_o
);
  import kx_pkg::*;

  word_t mem_q [DEPTH];
  word_t key_w [NK];

  for (genvar k = 0; k < NK; k++) begin : g_key
    assign key_w[k] = key_i[32*(NK-k)-1 -: 32];
  end

  always_ff @(posedge clk_i) begin
    if (load_i) begin
      for (int k = 0; k < NK; k++) mem_q[k] <= key_w[k];
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign ra_o = mem_q[ra_i];
  assign rb_o = mem_q[rb_i];
  assign rc_o = mem_q[rc_i];
endmodule

// File: rtl/kx_read_seq.sv
module kx_read_seq #(
  parameter int ROUNDS = 10,
  parameter int AW     = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          accept_i,
  input  logic          dec_i,
  output logic [AW-1:0] addr_o,
  output logic          start_o
);
  localparam int RW = $clog2(ROUNDS + 1);

  logic [RW-1:0] rnd_q;
  logic [1:0]    col_q;
  logic [RW-1:0] rsel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rnd_q <= '0;
      col_q <= '0;
    end else if (clear_i) begin
      rnd_q <= '0;
      col_q <= '0;
    end else if (accept_i) begin
      col_q <= col_q + 2'd1;
      if (col_q == 2'd3)
        rnd_q <= (rnd_q == RW'(ROUNDS)) ? '0 : rnd_q + 1'b1;
    end
  end

  // reversed round index for decryption, column order kept
  assign rsel    = dec_i ? (RW'(ROUNDS) - rnd_q) : rnd_q;
  assign addr_o  = AW'({rsel, col_q});
  assign start_o = (rnd_q == '0) && (col_q == '0);
endmodule

// File: rtl/kx_key_sched.sv
module kx_key_sched #(
  parameter int NK       = 4,
  parameter int SBOX_LAT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             key_load_i,
  input  logic [32*NK-1:0] key_i,
  input  logic             decrypt_i,
  input  logic             rk_req_i,
  output logic             ready_o,
  output logic             rk_valid_o,
  output logic [31:0]      rk_word_o,
  output logic             sbox_req_o,
  output logic [31:0]      sbox_word_o,
  input  logic             sbox_free_i,
  input  logic [31:0]      sbox_res_i
);
  import kx_pkg::*;

  localparam int ROUNDS = NK + 6;
  localparam int TOTAL  = 4 * (ROUNDS + 1);
  localparam int AW     = $clog2(TOTAL);
  localparam int IW     = $clog2(TOTAL + 1);
  localparam int CW     = (NK > 1) ? $clog2(NK) : 1;

  logic          key_ok_q;
  logic [IW-1:0] gen_idx_q;
  logic [CW-1:0] col_q;
  logic          dir_q;

  logic          gen_active, need_sub, col_first;
  logic          sb_start, sb_busy, sb_done;
  word_t         sb_in, sb_res;
  word_t         w_back, w_prev, w_rd, wr_data, rc_mask;
  logic          wr_en, rcon_step;
  logic [7:0]    rcon;
  logic [AW-1:0] rd_addr;
  logic          rd_start, eff_dec, accept;

  assign gen_active = key_ok_q && (gen_idx_q != IW'(TOTAL));
  assign col_first  = (col_q == '0);

  if (NK > 6) begin : g_wide
    assign need_sub = col_first || (col_q == CW'(4));
  end else begin : g_narrow
    assign need_sub = col_first;
  end

  assign sb_in    = col_first ? rot_word(w_prev) : w_prev;
  assign sb_start = gen_active && need_sub && !sb_busy && !key_load_i;
  assign wr_en    = gen_active && !key_load_i && (sb_done || (!need_sub && !sb_busy));
  assign rc_mask  = col_first ? {rcon, 24'h0} : 32'h0;
  assign wr_data  = sb_done ? (w_back ^ sb_res ^ rc_mask) : (w_back ^ w_prev);
  assign rcon_step = wr_en && sb_done && col_first;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_ok_q  <= 1'b0;
      gen_idx_q <= '0;
      col_q     <= '0;
    end else if (key_load_i) begin
      key_ok_q  <= 1'b1;
      gen_idx_q <= IW'(NK);
      col_q     <= '0;
    end else if (wr_en) begin
      gen_idx_q <= gen_idx_q + 1'b1;
      col_q     <= (col_q == CW'(NK - 1)) ? '0 : col_q + 1'b1;
    end
  end

  kx_rcon_gen u_rcon (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (key_load_i),
    .step_i  (rcon_step),
    .rcon_o  (rcon)
  );

  kx_sbox_client #(.LAT(SBOX_LAT)) u_sbc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .abort_i  (key_load_i),
    .start_i  (sb_start),
    .word_i   (sb_in),
    .free_i   (sbox_free_i),
    .res_i    (sbox_res_i),
    .req_o    (sbox_req_o),
    .word_o   (sbox_word_o),
    .busy_o   (sb_busy),
    .done_o   (sb_done),
    .result_o (sb_res)
  );

  kx_word_store #(.NK(NK), .DEPTH(TOTAL), .AW(AW)) u_store (
    .clk_i   (clk_i),
    .load_i  (key_load_i),
    .key_i   (key_i),
    .we_i    (wr_en),
    .waddr_i (AW'(gen_idx_q)),
    .wdata_i (wr_data),
    .ra_i    (AW'(gen_idx_q - IW'(NK))),
    .rb_i    (AW'(gen_idx_q - 1'b1)),
    .rc_i    (rd_addr),
    .ra_o    (w_back),
    .rb_o    (w_prev),
    .rc_o    (w_rd)
  );

  // direction latched on the first word of each pass
  assign eff_dec = rd_start ? decrypt_i : dir_q;

  kx_read_seq #(.ROUNDS(ROUNDS), .AW(AW)) u_rdseq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (key_load_i),
    .accept_i (accept),
    .dec_i    (eff_dec),
    .addr_o   (rd_addr),
    .start_o  (rd_start)
  );

  assign ready_o = key_ok_q &&
                   (eff_dec ? (gen_idx_q == IW'(TOTAL)) : (IW'(rd_addr) < gen_idx_q));
  assign accept  = rk_req_i && ready_o && !key_load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q      <= 1'b0;
      rk_valid_o <= 1'b0;
      rk_word_o  <= '0;
    end else begin
      rk_valid_o <= accept;
      if (accept) rk_word_o <= w_rd;
      if (accept && rd_start) dir_q <= decrypt_i;
    end
  end
endmodule

// File: rtl/kx_key_sched_chk.sv
module kx_key_sched_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        key_load_i,
  input logic        rk_req_i,
  input logic        ready_o,
  input logic        rk_valid_o,
  input logic        sbox_req_o,
  input logic [31:0] sbox_word_o,
  input logic        sbox_free_i
);
  p_req_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sbox_req_o && !sbox_free_i && !key_load_i) |=> (sbox_req_o && $stable(sbox_word_o)));

  p_req_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sbox_req_o && sbox_free_i) |=> !sbox_req_o);

  p_valid_next_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rk_req_i && ready_o && !key_load_i) |=> rk_valid_o);

  p_no_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rk_req_i && ready_o && !key_load_i) |=> !rk_valid_o);

  p_load_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_load_i |=> (!sbox_req_o && !rk_valid_o));
endmodule

bind kx_key_sched kx_key_sched_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .key_load_i  (key_load_i),
  .rk_req_i    (rk_req_i),
  .ready_o     (ready_o),
  .rk_valid_o  (rk_valid_o),
  .sbox_req_o  (sbox_req_o),
  .sbox_word_o (sbox_word_o),
  .sbox_free_i (sbox_free_i)
);

// File: tb/sim_kx_key_sched.sv
`timescale 1ns/1ps
module sim_kx_key_sched;
  localparam int LAT = 2;
  localparam logic [127:0] KEY_A = 128'h2b7e151628aed2a6abf7158809cf4f3c;
  localparam logic [127:0] KEY_B = 128'h000102030405060708090a0b0c0d0e0f;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b1;
  logic         key_load_i = 1'b0;
  logic [127:0] key_i = '0;
  logic         decrypt_i = 1'b0;
  logic         rk_req_i = 1'b0;
  logic         ready_o, rk_valid_o, sbox_req_o;
  logic [31:0]  rk_word_o, sbox_word_o, sbox_res_i;
  logic         sbox_free_i = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  int grants = 0;
  int free_mode = 0;  // 0 never, 1 always, 2 alternate
  logic [31:0] ref_w [44];

  always #5 clk_i = ~clk_i;

  kx_key_sched #(.NK(4), .SBOX_LAT(LAT)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .key_load_i(key_load_i), .key_i(key_i),
    .decrypt_i(decrypt_i), .rk_req_i(rk_req_i), .ready_o(ready_o),
    .rk_valid_o(rk_valid_o), .rk_word_o(rk_word_o), .sbox_req_o(sbox_req_o),
    .sbox_word_o(sbox_word_o), .sbox_free_i(sbox_free_i), .sbox_res_i(sbox_res_i)
  );

  // ---------------- reference arithmetic ----------------
  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 8'h00;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= a;
      a = {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    end
    return p;
  endfunction

  function automatic logic [7:0] sbyte(input logic [7:0] x);
    logic [7:0] b = 8'h01;
    for (int i = 0; i < 254; i++) b = gmul(b, x);
    return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]} ^ {b[3:0], b[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [31:0] sword(input logic [31:0] w);
    return {sbyte(w[31:24]), sbyte(w[23:16]), sbyte(w[15:8]), sbyte(w[7:0])};
  endfunction

  task automatic build_ref(input logic [127:0] k);
    logic [7:0] rc = 8'h01;
    logic [31:0] t;
    for (int i = 0; i < 4; i++) ref_w[i] = k[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = ref_w[i-1];
      if (i % 4 == 0) begin
        t = sword({t[23:0], t[31:24]}) ^ {rc, 24'h0};
        rc = {rc[6:0], 1'b0} ^ (rc[7] ? 8'h1b : 8'h00);
      end
      ref_w[i] = ref_w[i-4] ^ t;
    end
  endtask

  // ---------------- shared S-box model ----------------
  logic [31:0] pipe_q [LAT];
  logic        pv_q   [LAT];
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < LAT; s++) begin pv_q[s] <= 1'b0; pipe_q[s] <= '0; end
    end else begin
      pipe_q[0] <= sword(sbox_word_o);
      pv_q[0]   <= sbox_req_o && sbox_free_i;
      for (int s = 1; s < LAT; s++) begin
        pipe_q[s] <= pipe_q[s-1];
        pv_q[s]   <= pv_q[s-1];
      end
    end
  end
  assign sbox_res_i = pv_q[LAT-1] ? pipe_q[LAT-1] : 32'hdeadbeef;

  always @(posedge clk_i) if (sbox_req_o && sbox_free_i) grants++;

  always @(negedge clk_i)
    sbox_free_i <= (free_mode == 2) ? ~sbox_free_i : (free_mode == 1);

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_key(input logic [127:0] k);
    key_i = k;
    key_load_i = 1'b1;
    @(negedge clk_i);
    key_load_i = 1'b0;
  endtask

  task automatic read_word(output logic [31:0] w, output bit ok);
    int g = 0;
    while (!ready_o && g < 1000) begin @(negedge clk_i); g++; end
    ok = ready_o;
    rk_req_i = 1'b1;
    @(negedge clk_i);
    rk_req_i = 1'b0;
    w = rk_word_o;
    ok = ok && rk_valid_o;
  endtask

  task automatic read_pass(input bit dec, input string req);
    logic [31:0] w;
    bit ok;
    int bad = 0;
    int idx;
    logic [31:0] first_bad_a = '0, first_bad_e = '0;
    for (int k = 0; k < 44; k++) begin
      idx = dec ? (10 - k / 4) * 4 + (k % 4) : k;
      read_word(w, ok);
      if (!ok || w !== ref_w[idx]) begin
        if (bad == 0) begin first_bad_a = w; first_bad_e = ref_w[idx]; end
        bad++;
      end
    end
    check(bad == 0, req, first_bad_a, first_bad_e);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    check(ready_o == 1'b0, "R1 ready after reset", 32'(ready_o), 0);
    check(rk_valid_o == 1'b0 && sbox_req_o == 1'b0, "R1 valid/req after reset",
          {rk_valid_o, sbox_req_o}, 0);
    rk_req_i = 1'b1;
    @(negedge clk_i);
    rk_req_i = 1'b0;
    check(rk_valid_o == 1'b0, "R9 read without key ignored", 32'(rk_valid_o), 0);
  endtask

  task automatic t_encrypt;
    free_mode = 1;
    decrypt_i = 1'b0;
    build_ref(KEY_A);
    grants = 0;
    load_key(KEY_A);
    check(ready_o == 1'b1, "R4 encrypt ready after load", 32'(ready_o), 1);
    decrypt_i = 1'b1;
    #1;
    check(ready_o == 1'b0, "R4 decrypt not ready after load", 32'(ready_o), 0);
    decrypt_i = 1'b0;
    #1;
    read_pass(1'b0, "R2 R7 R12 forward words");
    check(ref_w[4] == 32'ha0fafe17, "R8 word 4", ref_w[4], 32'ha0fafe17);
    check(ref_w[43] == 32'hb6630ca6, "R8 word 43", ref_w[43], 32'hb6630ca6);
    check(grants == 10, "R6 grant count", 32'(grants), 10);
  endtask

  task automatic t_decrypt;
    int hi = 0;
    logic [31:0] w;
    bit ok;
    free_mode = 1;
    decrypt_i = 1'b1;
    build_ref(KEY_B);
    load_key(KEY_B);
    for (int c = 0; c < 20; c++) begin
      if (ready_o) hi++;
      @(negedge clk_i);
    end
    check(hi == 0, "R4 decrypt waits for full schedule", 32'(hi), 0);
    rk_req_i = 1'b1;
    @(negedge clk_i);
    rk_req_i = 1'b0;
    check(rk_valid_o == 1'b0, "R9 request while not ready", 32'(rk_valid_o), 0);
    read_pass(1'b1, "R3 reversed round order");
    decrypt_i = 1'b0;
    read_word(w, ok);
    check(ok && w === ref_w[0], "R10 wrap to forward word 0", w, ref_w[0]);
    decrypt_i = 1'b1;
    read_word(w, ok);
    check(ok && w === ref_w[1], "R10 direction held mid-pass", w, ref_w[1]);
  endtask

  task automatic t_starve;
    logic [31:0] held, w;
    bit ok;
    int bad = 0;
    free_mode = 0;
    decrypt_i = 1'b0;
    build_ref(KEY_A);
    load_key(KEY_A);
    repeat (8) @(negedge clk_i);
    held = sbox_word_o;
    check(sbox_req_o == 1'b1, "R5 request raised", 32'(sbox_req_o), 1);
    check(held === {ref_w[3][23:0], ref_w[3][31:24]}, "R5 rotated word", held,
          {ref_w[3][23:0], ref_w[3][31:24]});
    repeat (8) @(negedge clk_i);
    check(sbox_req_o == 1'b1 && sbox_word_o === held, "R5 held without grant", sbox_word_o, held);
    for (int k = 0; k < 4; k++) begin
      read_word(w, ok);
      if (!ok || w !== ref_w[k]) bad++;
    end
    check(bad == 0, "R2 key words before substitution", 32'(bad), 0);
    repeat (3) @(negedge clk_i);
    check(ready_o == 1'b0, "R4 stalled word not ready", 32'(ready_o), 0);
    free_mode = 2;
    bad = 0;
    for (int k = 4; k < 44; k++) begin
      read_word(w, ok);
      if (!ok || w !== ref_w[k]) bad++;
    end
    check(bad == 0, "R7 alternating grants", 32'(bad), 0);
  endtask

  task automatic t_reload;
    free_mode = 1;
    decrypt_i = 1'b0;
    load_key(KEY_A);
    repeat (13) @(negedge clk_i);
    build_ref(KEY_B);
    grants = 0;
    load_key(KEY_B);
    check(sbox_req_o == 1'b0, "R11 request cleared by load", 32'(sbox_req_o), 0);
    read_pass(1'b0, "R11 reload schedule");
    check(grants == 10, "R11 R6 grants after reload", 32'(grants), 10);
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_encrypt();
    t_decrypt();
    t_starve();
    t_reload();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule